// File: doc/BRIEF.md
# Pixel to Seven-Slot Lane Serializer

The block takes one parallel RGB pixel in each pixel period, together with three timing-control bits. It spreads the pixel over up to four serial data lanes, with seven bit slots per pixel period, and sends a matching seven-slot lane clock pattern beside them. It runs on a fast slot clock at seven times the pixel rate. An internal slot counter marks one cycle in seven as the capture cycle, and the `pix_take_o` strobe tells the pixel source when the next pixel is taken.

A two-bit format input selects the lane layout:
- an 18-bit layout on three lanes;
- a 24-bit four-lane layout in which lanes 0 to 2 carry colour bits 2 to 7;
- a 24-bit four-lane layout in which lanes 0 to 2 carry colour bits 0 to 5, as in the 18-bit layout, and the fourth lane carries the remaining bits.

The pixel and the format are latched together. A format change therefore takes effect only at a pixel boundary and never mixes two layouts within one pixel.

Top module: `px_lane_ser`

## Requirements
- R1: The slot counter steps 0,1,...,6 and wraps to 0. `pix_take_o` is high exactly in the cycles where the counter is 0, which is one cycle in every seven. The counter is 0 in the first cycle after reset.
- R2: Pixel inputs and `fmt_i` are sampled only at the rising edge that ends a `pix_take_o` cycle. Values driven in any other cycle have no effect on the pixel being sent.
- R3: In the seven cycles after a capture edge, the lanes present slots 0 through 6 of the captured pixel in order, one slot per cycle.
- R4: `lclk_o` carries the pattern 1,1,0,0,0,1,1 over slots 0 to 6 of every sent pixel.
- R5: With `fmt_i` = 0 (18-bit), lanes 0 to 2 send, slot 0 first: lane 0 G0,R5,R4,R3,R2,R1,R0; lane 1 B1,B0,G5,G4,G3,G2,G1; lane 2 C2,C1,C0,B5,B4,B3,B2. The bit numbers index the 8-bit colour inputs.
- R6: With `fmt_i` = 0, and with the reserved code 3, which behaves as 0, lane 3 stays low.
- R7: With `fmt_i` = 1 (24-bit, upper bits on lanes 0 to 2), lanes 0 to 2 follow the R5 map with every colour bit index raised by 2. For example, lane 0 sends G2,R7,R6,R5,R4,R3,R2.
- R8: With `fmt_i` = 1, lane 3 sends R1,R0,G1,G0,B1,B0 and then a low reserved slot.
- R9: With `fmt_i` = 2 (24-bit, lower bits on lanes 0 to 2), lanes 0 to 2 follow the R5 map exactly. Lane 3 sends R7,R6,G7,G6,B7,B6 and then a low reserved slot.
- R10: The control slots are driven as follows in every format: C2 = `de_i`, C1 = `vsync_i`, C0 = `hsync_i`.
- R11: While `rst_ni` is low, the block is reset asynchronously. After reset, all data lanes and `lclk_o` stay low until the first pixel has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| red_i | input | 8 | Red channel of the pixel |
| grn_i | input | 8 | Green channel of the pixel |
| blu_i | input | 8 | Blue channel of the pixel |
| de_i | input | 1 | Data enable control bit |
| vsync_i | input | 1 | Vertical sync control bit |
| hsync_i | input | 1 | Horizontal sync control bit |
| fmt_i | input | 2 | Lane layout: 0 18-bit, 1 24-bit upper, 2 24-bit lower, 3 as 0 |
| pix_take_o | output | 1 | High in the cycle whose closing edge captures the pixel |
| lane_o | output | 4 | Serial data lanes, one bit per slot |
| lclk_o | output | 1 | Seven-slot lane clock pattern |

## Verification
A slot counter that slips or skips a state shows up within one pixel period in two ways. `pix_take_o` falls off its seven-cycle rhythm, and the 1,1,0,0,0,1,1 pattern on `lclk_o` loses its shape. A wrongly mapped bit or a stale format latch shows only on the lane and slot that carry that bit. For this reason the bench drives colour values with distinct bits, compares all four lanes in every slot against its own mapping function, and varies the inputs in the middle of a pixel to expose capture at the wrong edge. A stuck started flag or a bad shift register load shows on the first pixel after reset, so a reset in the middle of a pixel is repeated during the run.

// File: rtl/px_ser_pkg.sv
`timescale 1ns/1ps
package px_ser_pkg;
  localparam int SLOTS = 7;
  localparam int LANES = 4;
  localparam int CW    = 8;
  localparam int CNT_W = $clog2(SLOTS);

  typedef enum logic [1:0] {
    FMT_18    = 2'd0,
    FMT_24_HI = 2'd1,
    FMT_24_LO = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [CW-1:0] r;
    logic [CW-1:0] g;
    logic [CW-1:0] b;
    logic          de;
    logic          vs;
    logic          hs;
  } pix_t;

  // bit s = slot s
  localparam logic [SLOTS-1:0] LCLK_PAT = 7'b1100011;
endpackage

// File: rtl/px_slot_ctr.sv
`timescale 1ns/1ps
module px_slot_ctr
  import px_ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] slot_o,
  output logic             take_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  logic [CNT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;
  assign take_o = (slot_q == '0);

  assert_slot_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST);
  assert_slot_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1));
  assert_slot_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == LAST) |=> take_o);
  assert_take_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
endmodule

// File: rtl/px_lane_map.sv
`timescale 1ns/1ps
module px_lane_map
  import px_ser_pkg::*;
(
  input  pix_t                        pix_i,
  input  fmt_e                        fmt_i,
  output logic [LANES-1:0][SLOTS-1:0] pat_o
);
  // lanes 0..2: colour bits o..o+5, slot 0 in bit 0
  function automatic logic [2:0][SLOTS-1:0] base_lanes(pix_t p, int o);
    logic [2:0][SLOTS-1:0] l;
    l[0] = {p.r[o], p.r[o+1], p.r[o+2], p.r[o+3], p.r[o+4], p.r[o+5], p.g[o]};
    l[1] = {p.g[o+1], p.g[o+2], p.g[o+3], p.g[o+4], p.g[o+5], p.b[o], p.b[o+1]};
    l[2] = {p.b[o+2], p.b[o+3], p.b[o+4], p.b[o+5], p.hs, p.vs, p.de};
    return l;
  endfunction

  // lane 3: the two remaining bits per channel, high bit first, reserved slot low
  function automatic logic [SLOTS-1:0] extra_lane(pix_t p, int q);
    return {1'b0, p.b[q], p.b[q+1], p.g[q], p.g[q+1], p.r[q], p.r[q+1]};
  endfunction

  logic [2:0][SLOTS-1:0] lo_map, hi_map;

  assign lo_map = base_lanes(pix_i, 0);
  assign hi_map = base_lanes(pix_i, 2);

  always_comb begin
    unique case (fmt_i)
      FMT_24_HI: begin
        pat_o[2:0] = hi_map;
        pat_o[3]   = extra_lane(pix_i, 0);
      end
      FMT_24_LO: begin
        pat_o[2:0] = lo_map;
        pat_o[3]   = extra_lane(pix_i, 6);
      end
      default: begin
        pat_o[2:0] = lo_map;
        pat_o[3]   = '0;
      end
    endcase
  end
endmodule

// File: rtl/px_lane_shift.sv
`timescale 1ns/1ps
module px_lane_shift #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] pat_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= pat_i;
    else             sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/px_lane_ser.sv
`timescale 1ns/1ps
module px_lane_ser
  import px_ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    red_i,
  input  logic [CW-1:0]    grn_i,
  input  logic [CW-1:0]    blu_i,
  input  logic             de_i,
  input  logic             vsync_i,
  input  logic             hsync_i,
  input  logic [1:0]       fmt_i,
  output logic             pix_take_o,
  output logic [LANES-1:0] lane_o,
  output logic             lclk_o
);
  logic [CNT_W-1:0]            slot;
  logic                        take;
  pix_t                        pix;
  logic [LANES-1:0][SLOTS-1:0] pat;
  logic                        started_q;
  fmt_e                        fmt_q;

  assign pix = '{r: red_i, g: grn_i, b: blu_i, de: de_i, vs: vsync_i, hs: hsync_i};

  px_slot_ctr u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot),
    .take_o (take)
  );

  px_lane_map u_map (
    .pix_i (pix),
    .fmt_i (fmt_e'(fmt_i)),
    .pat_o (pat)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    px_lane_shift #(.W(SLOTS)) u_sh (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (take),
      .pat_i  (pat[l]),
      .bit_o  (lane_o[l])
    );
  end

  px_lane_shift #(.W(SLOTS)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take),
    .pat_i  (LCLK_PAT),
    .bit_o  (lclk_o)
  );

  // format of the pixel in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      fmt_q     <= FMT_18;
    end else if (take) begin
      started_q <= 1'b1;
      fmt_q     <= fmt_e'(fmt_i);
    end
  end

  assign pix_take_o = take;

  assert_idle_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> (lane_o == '0 && !lclk_o));
  assert_lclk_lead_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> lclk_o);
  assert_lclk_mid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && slot == CNT_W'(3)) |-> !lclk_o);
  assert_lane3_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && (fmt_q == FMT_18 || fmt_q == FMT_RSVD)) |-> !lane_o[3]);
  assert_rsvd_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && take) |-> !lane_o[3]);
endmodule

// File: tb/sim_px_lane_ser.sv
`timescale 1ns/1ps
module sim_px_lane_ser;
  localparam time TCK = 8ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] red_i = '0, grn_i = '0, blu_i = '0;
  logic       de_i = 1'b0, vsync_i = 1'b0, hsync_i = 1'b0;
  logic [1:0] fmt_i = '0;
  logic       pix_take_o;
  logic [3:0] lane_o;
  logic       lclk_o;

  int checks = 0;
  int errors = 0;

  always #(TCK/2) clk_i = ~clk_i;

  px_lane_ser u0 (
    .clk_i, .rst_ni, .red_i, .grn_i, .blu_i, .de_i, .vsync_i, .hsync_i,
    .fmt_i, .pix_take_o, .lane_o, .lclk_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected bit of lane ln in slot s
  function automatic logic exp_bit(int ln, int s, logic [1:0] f,
                                   logic [7:0] r, logic [7:0] g, logic [7:0] b,
                                   logic de, logic vs, logic hs);
    int o = (f == 2'd1) ? 2 : 0;
    int q = (f == 2'd1) ? 0 : 6;
    logic [6:0] x;
    case (ln)
      0: return (s == 0) ? g[o] : r[o+6-s];
      1: return (s == 0) ? b[o+1] : (s == 1) ? b[o] : g[o+7-s];
      2: begin
        if (s == 0) return de;
        if (s == 1) return vs;
        if (s == 2) return hs;
        return b[o+8-s];
      end
      default: begin
        if (f == 2'd0 || f == 2'd3) return 1'b0;
        x = {1'b0, b[q], b[q+1], g[q], g[q+1], r[q], r[q+1]};
        return x[s];
      end
    endcase
  endfunction

  function automatic string lane_tag(int ln, int s, logic [1:0] f);
    if (ln == 2 && s < 3) return "R10";
    if (ln == 3) return (f == 2'd1) ? "R8" : (f == 2'd2) ? "R9" : "R6";
    return (f == 2'd1) ? "R7" : (f == 2'd2) ? "R9" : "R5";
  endfunction

  task automatic scramble();
    red_i = 8'($urandom); grn_i = 8'($urandom); blu_i = 8'($urandom);
    {de_i, vsync_i, hsync_i} = 3'($urandom);
    fmt_i = 2'($urandom);
  endtask

  // called at a negedge inside a take cycle
  task automatic send(logic [1:0] f, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                      logic [2:0] ctl, string tag, bit mix);
    logic [6:0] lpat = 7'b1100011;
    chk("R1 take", 32'(pix_take_o), 32'd1);
    fmt_i = f; red_i = r; grn_i = g; blu_i = b; {de_i, vsync_i, hsync_i} = ctl;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk_i);
      for (int ln = 0; ln < 4; ln++)
        chk(mix ? "R2" : (tag != "" ? tag : lane_tag(ln, s, f)), 32'(lane_o[ln]),
            32'(exp_bit(ln, s, f, r, g, b, ctl[2], ctl[1], ctl[0])));
      chk("R4", 32'(lclk_o), 32'(lpat[s]));
      if (s < 6) chk("R1 no take", 32'(pix_take_o), 32'd0);
      if (mix && s < 6) scramble();
    end
  endtask

  initial begin : watchdog
    #(TCK * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk_i);
    chk("R11 lanes in reset", 32'(lane_o), 32'd0);
    chk("R11 lclk in reset", 32'(lclk_o), 32'd0);
    rst_ni = 1'b1;
    chk("R11 idle after reset", 32'({lane_o, lclk_o}), 32'd0);
    chk("R1 counter starts 0", 32'(pix_take_o), 32'd1);

    // first pixel: slot timing
    send(2'd0, 8'h5A, 8'hC3, 8'h96, 3'b101, "R3", 1'b0);
    // directed per format
    for (int f = 0; f < 4; f++) begin
      send(2'(f), 8'hFF, 8'hFF, 8'hFF, 3'b111, "", 1'b0);
      send(2'(f), 8'h00, 8'h00, 8'h00, 3'b000, "", 1'b0);
      send(2'(f), 8'hA5, 8'h3C, 8'h81, 3'b010, "", 1'b0);
      send(2'(f), 8'h01, 8'h80, 8'h40, 3'b100, "", 1'b0);
    end
    // inputs churn mid-pixel, incl. format
    for (int i = 0; i < 20; i++)
      send(2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom), "", 1'b1);
    // reset in the middle of a pixel
    fmt_i = 2'd2; red_i = 8'hFF; grn_i = 8'hFF; blu_i = 8'hFF; {de_i, vsync_i, hsync_i} = 3'b111;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R11 async clear", 32'({lane_o, lclk_o}), 32'd0);
    chk("R11 counter clear", 32'(pix_take_o), 32'd1);
    repeat (2) @(negedge clk_i);
    chk("R11 held", 32'({lane_o, lclk_o}), 32'd0);
    rst_ni = 1'b1;
    chk("R11 idle before capture", 32'({lane_o, lclk_o}), 32'd0);
    send(2'd1, 8'h96, 8'h69, 8'hF0, 3'b011, "R3", 1'b0);
    // random run
    for (int i = 0; i < 80; i++)
      send(2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom), "", 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule